// File: doc/BRIEF.md
# Serial Frequency-Synthesizer Programming Loader

This block takes a three-wire serial stream (shift clock, data, load enable) and fills a set of parallel divider settings for a frequency synthesizer. All three wires are sampled by the system clock `clk`. A rising edge on the shift clock moves one data bit into a 20-bit shift register. The stream is sent most-significant bit first, so the control bit, which is the least-significant bit, is the last one shifted in. A rising edge on load enable copies the shifted word into one of two latches, chosen by that control bit.

The reference latch holds a 14-bit reference division ratio and a prescaler-select bit. The main latch holds an 11-bit programmable count and an 8-bit swallow count. A reference ratio below 8 is refused: the latch keeps its old contents and an error flag pulses for one clock. After reset both latches are zero, and a not-configured flag stays high until each latch has accepted one valid load.

Top module: `pll_serial_loader`

## Requirements
- R1: After reset, every latch output is zero, `unconfigured` is 1 and `ref_error` is 0.
- R2: Each rising edge of `ser_clk` shifts exactly one `ser_data` bit into the shift register, most-significant bit first. The last bit shifted in becomes bit 0 of the word.
- R3: On a `ser_le` rising edge with word bit 0 = 1, the reference latch loads `ref_ratio` from word bits 14..1 and `presc_sel` from word bit 15. The main latch is unchanged.
- R4: On a `ser_le` rising edge with word bit 0 = 0, the main latch loads `main_a` from word bits 8..1 and `main_n` from word bits 19..9. The reference latch is unchanged.
- R5: `presc_sel` = 1 means a 128/129 prescaler and 0 means 256/257. It follows the loaded bit for both values.
- R6: A reference load whose ratio is below 8 leaves `ref_ratio` and `presc_sel` unchanged. It raises `ref_error` for exactly one clock, in the cycle after the load-enable edge.
- R7: `unconfigured` stays 1 until both latches have taken one accepted load, then stays 0. A refused reference load does not count.
- R8: The latch outputs change only on a `ser_le` rising edge. Shifting while `ser_le` is low, or while it is held high, leaves them unchanged.
- R9: Ratio boundaries: 7 is refused, while 8 and 16383 are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock; each rising edge shifts in one bit |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load enable; a rising edge transfers the word to a latch |
| ref_ratio | output | 14 | Reference division ratio |
| presc_sel | output | 1 | Prescaler select (1: 128/129, 0: 256/257) |
| main_n | output | 11 | Programmable count |
| main_a | output | 8 | Swallow count |
| ref_error | output | 1 | One-clock pulse when a reference load is refused |
| unconfigured | output | 1 | High until both latches have been loaded once |

## Verification
Reference ratios are swept through every value from 0 to 63, plus the top value 16383, with the prescaler bit alternating. This separates refused ratios from accepted ones at the exact boundary of 8 and exposes any bit-order slip in the ratio field. Walking-one patterns across all 19 main-latch bits show that each bit lands in its own field with no crossover into the reference latch. Further sequences test shifting with load enable low and with it held high, and a refused load sent before configuration. These show that the latches move only on a load edge and that the not-configured flag ignores refused loads.

// File: rtl/pll_loader_pkg.sv
package pll_loader_pkg;
    parameter int REF_W = 14;
    parameter int N_W   = 11;
    parameter int A_W   = 8;
    parameter int R_MIN = 8;
    localparam int SR_W = 1 + A_W + N_W;

    typedef struct packed {
        logic [REF_W-1:0] ref_ratio;
        logic             presc;
        logic [N_W-1:0]   n_cnt;
        logic [A_W-1:0]   a_cnt;
        logic             ref_done;
        logic             main_done;
        logic             err;
    } latch_t;
endpackage

// File: rtl/pll_edge_det.sv
module pll_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_rise
        assign rise[i] = sig[i] & ~prev_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pll_shift_reg.sv
module pll_shift_reg #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word = sr_q;
endmodule

// File: rtl/pll_latch_bank.sv
module pll_latch_bank
    import pll_loader_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SR_W-1:0] word,
    output latch_t          st
);
    localparam int REF_LO = 1;
    localparam int REF_HI = REF_W;
    localparam int SW_POS = REF_W + 1;
    localparam int A_LO   = 1;
    localparam int A_HI   = A_W;
    localparam int N_LO   = A_W + 1;
    localparam int N_HI   = A_W + N_W;

    latch_t st_d, st_q;
    logic [REF_W-1:0] new_ref;

    always_comb begin
        new_ref = word[REF_HI:REF_LO];
        st_d     = st_q;
        st_d.err = 1'b0;
        if (load) begin
            if (word[0]) begin
                if (new_ref < REF_W'(R_MIN)) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.ref_ratio = new_ref;
                    st_d.presc     = word[SW_POS];
                    st_d.ref_done  = 1'b1;
                end
            end else begin
                st_d.a_cnt     = word[A_HI:A_LO];
                st_d.n_cnt     = word[N_HI:N_LO];
                st_d.main_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/pll_serial_loader.sv
module pll_serial_loader
    import pll_loader_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic [REF_W-1:0] ref_ratio,
    output logic             presc_sel,
    output logic [N_W-1:0]   main_n,
    output logic [A_W-1:0]   main_a,
    output logic             ref_error,
    output logic             unconfigured
);
    logic [1:0]      rise;
    logic [SR_W-1:0] word;
    latch_t          st;

    pll_edge_det #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({ser_le, ser_clk}),
        .rise (rise)
    );

    pll_shift_reg #(.W(SR_W)) u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(rise[0]),
        .din     (ser_data),
        .word    (word)
    );

    pll_latch_bank u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .load (rise[1]),
        .word (word),
        .st   (st)
    );

    assign ref_ratio    = st.ref_ratio;
    assign presc_sel    = st.presc;
    assign main_n       = st.n_cnt;
    assign main_a       = st.a_cnt;
    assign ref_error    = st.err;
    assign unconfigured = ~(st.ref_done & st.main_done);
endmodule

// File: rtl/pll_serial_loader_chk.sv
module pll_serial_loader_chk
    import pll_loader_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ser_le,
    input logic [REF_W-1:0] ref_ratio,
    input logic             presc_sel,
    input logic [N_W-1:0]   main_n,
    input logic [A_W-1:0]   main_a,
    input logic             ref_error,
    input logic             unconfigured
);
    // R6
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_error |=> !ref_error);

    // R6
    err_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_error |-> ($stable(ref_ratio) && $stable(presc_sel)));

    // R7
    config_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unconfigured |=> !unconfigured);

    // R8
    ref_only_on_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(ref_ratio) && $stable(presc_sel)) |-> $past(ser_le));

    // R8
    main_only_on_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(main_n) && $stable(main_a)) |-> $past(ser_le));

    // R9
    ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ratio == '0) || (ref_ratio >= REF_W'(R_MIN)));
endmodule

bind pll_serial_loader pll_serial_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_le      (ser_le),
    .ref_ratio   (ref_ratio),
    .presc_sel   (presc_sel),
    .main_n      (main_n),
    .main_a      (main_a),
    .ref_error   (ref_error),
    .unconfigured(unconfigured)
);

// File: tb/sim_pll_serial_loader.sv
module sim_pll_serial_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic        presc_sel;
    logic [10:0] main_n;
    logic [7:0]  main_a;
    logic        ref_error, unconfigured;

    int tests = 0;
    int fails = 0;

    logic [13:0] e_ref = '0;
    logic        e_sw  = 1'b0;
    logic [10:0] e_n   = '0;
    logic [7:0]  e_a   = '0;
    logic        ref_ok = 1'b0, main_ok = 1'b0;
    logic        err_seen, err_after;

    always #4 clk = ~clk;

    pll_serial_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .ref_ratio(ref_ratio), .presc_sel(presc_sel),
        .main_n(main_n), .main_a(main_a), .ref_error(ref_error),
        .unconfigured(unconfigured)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [19:0] w, input int len);
        for (int i = len - 1; i >= 0; i--) begin
            ser_data = w[i];
            ser_clk = 1'b0;
            tick(1);
            ser_clk = 1'b1;
            tick(1);
        end
        ser_clk = 1'b0;
        tick(1);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        tick(1);
        err_seen = ref_error;
        ser_le = 1'b0;
        tick(1);
        err_after = ref_error;
    endtask

    task automatic check_all(input string req);
        check(ref_ratio == e_ref, req, ref_ratio, e_ref);
        check(presc_sel == e_sw, req, presc_sel, e_sw);
        check(main_n == e_n, req, main_n, e_n);
        check(main_a == e_a, req, main_a, e_a);
        check(unconfigured == !(ref_ok && main_ok), req, unconfigured, !(ref_ok && main_ok));
    endtask

    task automatic load_ref(input int r, input logic sw, input string req);
        logic [15:0] w;
        logic bad;
        w = {sw, 14'(r), 1'b1};
        bad = (r < 8);
        shift_word({4'h0, w}, 16);
        pulse_le();
        if (!bad) begin
            e_ref = 14'(r);
            e_sw = sw;
            ref_ok = 1'b1;
        end
        check(err_seen == bad, req, err_seen, bad);
        check(err_after == 1'b0, "R6", err_after, 0);
        check_all(req);
    endtask

    task automatic load_main(input logic [10:0] n, input logic [7:0] a, input string req);
        shift_word({n, a, 1'b0}, 20);
        pulse_le();
        e_n = n;
        e_a = a;
        main_ok = 1'b1;
        check(err_seen == 1'b0, req, err_seen, 0);
        check_all(req);
    endtask

    initial begin : watchdog
        #1600000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        // R1 reset values
        check_all("R1");
        check(ref_error == 1'b0, "R1", ref_error, 0);
        rst_n = 1'b1;
        tick(1);
        check_all("R1");

        // R7 a refused load before configuration does not count
        load_ref(3, 1'b1, "R6");
        load_main(11'd100, 8'd7, "R4");
        check(unconfigured == 1'b1, "R7", unconfigured, 1);

        // R9 boundaries
        load_ref(7, 1'b0, "R9");
        load_ref(8, 1'b1, "R9");
        check(unconfigured == 1'b0, "R7", unconfigured, 0);
        load_ref(16383, 1'b0, "R9");

        // R3 R5 R6 sweep of reference ratios, prescaler bit alternating
        for (int r = 0; r < 64; r++) load_ref(r, r[0], "R3");
        load_ref(16383, 1'b1, "R5");
        load_ref(16383, 1'b0, "R5");

        // R2 R4 walking ones across the main word
        for (int b = 0; b < 19; b++) begin
            logic [18:0] v;
            v = 19'(1) << b;
            load_main(v[18:8], v[7:0], "R2");
        end
        load_main(11'h7FF, 8'hFF, "R4");
        load_main(11'h555, 8'hAA, "R4");

        // R8 shifting without a load edge changes nothing
        shift_word(20'hFFFF1, 20);
        tick(2);
        check_all("R8");

        // R8 load enable held high while a new word is shifted in
        shift_word({11'd300, 8'd12, 1'b0}, 20);
        ser_le = 1'b1;
        tick(1);
        e_n = 11'd300;
        e_a = 8'd12;
        shift_word({11'd9, 8'd1, 1'b0}, 20);
        check_all("R8");
        ser_le = 1'b0;
        tick(2);
        check_all("R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule